// File: doc/BRIEF.md
# Idle and Power-Down State Controller

This block decides the power state of a small microcontroller. Software can ask for a light sleep (idle) or a deep sleep (power-down). The block turns those requests, the enabled interrupt requests and the external reset pin into four registered enables: the CPU core clock, the peripheral clock, the oscillator, and an inhibit that blocks internal RAM access. It also drives an internal reset for the core.

In idle, the core clock stops while the peripherals and the oscillator keep running, so state is held and timers can keep counting. Any pending, enabled interrupt wakes the core. Power-down stops everything, including the oscillator. Only a reset pulse on the pin that lasts long enough wakes it from there. A valid reset enters a hold state. The hold keeps the core in reset while the pin is high, then for a programmable settling time after the pin falls. If the pin rises while the core is idle, the core clock restarts at once. From then until the reset is confirmed, internal RAM access is blocked and port access is left alone.

Top module: `pwr_state_ctrl`

## Requirements
- R1: In run (all enables high, internal reset low, no inhibit, reset pin low), an idle request without a power-down request makes the next cycle show CPU clock enable 0, peripheral clock enable 1 and oscillator enable 1.
- R2: In run with the reset pin low, a power-down request, alone or together with an idle request, makes the next cycle show all three enables at 0.
- R3: In idle, the core returns to run on the next cycle when some bit has both interrupt pending and interrupt enable set. Pending bits whose enable is clear leave the block idle.
- R4: In power-down, interrupts, requests and reset-pin pulses shorter than the valid length are ignored, and the oscillator enable stays 0.
- R5: The reset pin counts as a valid reset only after it has been high for MC_CLKS*MIN_RST_MC consecutive clocks. Internal reset rises on the clock edge that completes that count, and a shorter pulse leaves it at 0.
- R6: Once reset is valid, internal reset and all three enables are 1. Internal reset stays high while the pin stays high and for HOLD_CYCLES clocks after the pin goes low, and then the block is in run.
- R7: In idle, a reset pin going high sets CPU clock enable and RAM access inhibit to 1 on the next cycle. The inhibit stays high while the pin stays high. It clears on the edge where internal reset rises, or on the first cycle the pin is seen low again.
- R8: While rst_n is low, the outputs are: internal reset 1, all enables 1, inhibit 0. After release with the pin low, internal reset falls after HOLD_CYCLES clocks.
- R9: In run, idle and power-down requests are ignored while the reset pin is high or the RAM inhibit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running reference clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin | input | 1 | External reset pin, active high, synchronous to clk |
| idle_req | input | 1 | Software request to enter idle |
| pd_req | input | 1 | Software request to enter power-down |
| irq_pend | input | NUM_IRQ | Pending interrupt requests |
| irq_en | input | NUM_IRQ | Interrupt enable mask |
| cpu_clk_en | output | 1 | Registered CPU core clock enable |
| periph_clk_en | output | 1 | Registered peripheral clock enable |
| osc_en | output | 1 | Registered oscillator enable |
| ram_access_inhibit | output | 1 | Registered block on internal RAM reads and writes |
| core_reset | output | 1 | Registered internal reset for the core |

## Verification
The checker checks these rules on every cycle:
- the request transitions out of run;
- the interrupt wake from idle;
- power-down holding through anything but the reset pin;
- the inhibit only ever rising after the pin is seen high;
- the inhibit never overlapping the internal reset.

Some behaviour depends on how long the pin stays high, so only the bench's scenarios can show it:
- the exact length of the pin filter, measured with pulses one clock short of valid and longer;
- the exact number of settling clocks;
- the way the inhibit window ends when a pulse is too short.

The bench also walks every pending/enable pattern of a small interrupt vector, so that each wake decision is checked.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;

    typedef enum logic [1:0] {
        PS_RUN  = 2'd0,
        PS_IDLE = 2'd1,
        PS_PD   = 2'd2,
        PS_HOLD = 2'd3
    } pwr_state_e;

    typedef struct packed {
        logic cpu;
        logic per;
        logic osc;
        logic crst;
    } pwr_gate_s;

    // Clock enables and internal reset that belong to a given state
    function automatic pwr_gate_s gate_of(input pwr_state_e st);
        pwr_gate_s g;
        g.cpu  = (st == PS_RUN) || (st == PS_HOLD);
        g.per  = (st != PS_PD);
        g.osc  = (st != PS_PD);
        g.crst = (st == PS_HOLD);
        return g;
    endfunction

endpackage

// File: rtl/pwr_rst_filter.sv
// Qualifies the reset pin: asserts hit once it has been high for LIM clocks
module pwr_rst_filter #(
    parameter int LIM = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic hit
);
    localparam int W = (LIM > 1) ? $clog2(LIM) : 1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!pin) begin
            cnt_d = '0;
        end else if (cnt_q != W'(LIM - 1)) begin
            cnt_d = cnt_q + W'(1);
        end
    end

    assign hit = pin && (cnt_q == W'(LIM - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/pwr_wake_detect.sv
// Flags any interrupt that is both pending and enabled
module pwr_wake_detect #(
    parameter int N = 6
) (
    input  logic [N-1:0] pend,
    input  logic [N-1:0] en,
    output logic         wake
);
    logic [N-1:0] live;

    for (genvar i = 0; i < N; i++) begin : g_line
        assign live[i] = pend[i] & en[i];
    end

    assign wake = |live;

endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
    import pwr_state_pkg::*;
#(
    parameter int MC_CLKS     = 12,
    parameter int MIN_RST_MC  = 2,
    parameter int HOLD_CYCLES = 64,
    parameter int NUM_IRQ     = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rst_pin,
    input  logic               idle_req,
    input  logic               pd_req,
    input  logic [NUM_IRQ-1:0] irq_pend,
    input  logic [NUM_IRQ-1:0] irq_en,
    output logic               cpu_clk_en,
    output logic               periph_clk_en,
    output logic               osc_en,
    output logic               ram_access_inhibit,
    output logic               core_reset
);
    localparam int RST_CLKS = MC_CLKS * MIN_RST_MC;
    localparam int HOLD_W   = $clog2(HOLD_CYCLES + 1);

    typedef struct packed {
        pwr_state_e        st;
        logic [HOLD_W-1:0] hold;
        logic              inh;
        pwr_gate_s         gate;
    } ctrl_s;

    ctrl_s cur_q, nxt_d;
    logic  rst_hit;
    logic  wake;

    pwr_rst_filter #(.LIM(RST_CLKS)) filt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (rst_pin),
        .hit   (rst_hit)
    );

    pwr_wake_detect #(.N(NUM_IRQ)) wake_i (
        .pend (irq_pend),
        .en   (irq_en),
        .wake (wake)
    );

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.st)
            PS_RUN: begin
                if (rst_hit) begin
                    nxt_d.st   = PS_HOLD;
                    nxt_d.hold = '0;
                    nxt_d.inh  = 1'b0;
                end else if (cur_q.inh) begin
                    if (!rst_pin) nxt_d.inh = 1'b0;
                end else if (!rst_pin) begin
                    if (pd_req)        nxt_d.st = PS_PD;
                    else if (idle_req) nxt_d.st = PS_IDLE;
                end
            end
            PS_IDLE: begin
                if (rst_hit) begin
                    nxt_d.st   = PS_HOLD;
                    nxt_d.hold = '0;
                end else if (rst_pin) begin
                    nxt_d.st  = PS_RUN;
                    nxt_d.inh = 1'b1;
                end else if (wake) begin
                    nxt_d.st = PS_RUN;
                end
            end
            PS_PD: begin
                if (rst_hit) begin
                    nxt_d.st   = PS_HOLD;
                    nxt_d.hold = '0;
                end
            end
            PS_HOLD: begin
                if (rst_pin) begin
                    nxt_d.hold = '0;
                end else if (cur_q.hold == HOLD_W'(HOLD_CYCLES - 1)) begin
                    nxt_d.st   = PS_RUN;
                    nxt_d.hold = '0;
                end else begin
                    nxt_d.hold = cur_q.hold + HOLD_W'(1);
                end
            end
            default: nxt_d.st = PS_HOLD;
        endcase
        nxt_d.gate = gate_of(nxt_d.st);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.st   <= PS_HOLD;
            cur_q.hold <= '0;
            cur_q.inh  <= 1'b0;
            cur_q.gate <= gate_of(PS_HOLD);
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign cpu_clk_en         = cur_q.gate.cpu;
    assign periph_clk_en      = cur_q.gate.per;
    assign osc_en             = cur_q.gate.osc;
    assign core_reset         = cur_q.gate.crst;
    assign ram_access_inhibit = cur_q.inh;

endmodule

// File: rtl/pwr_state_ctrl_chk.sv
module pwr_state_ctrl_chk #(
    parameter int NUM_IRQ = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rst_pin,
    input logic               idle_req,
    input logic               pd_req,
    input logic [NUM_IRQ-1:0] irq_pend,
    input logic [NUM_IRQ-1:0] irq_en,
    input logic               cpu_clk_en,
    input logic               periph_clk_en,
    input logic               osc_en,
    input logic               ram_access_inhibit,
    input logic               core_reset
);
    logic in_run;
    assign in_run = cpu_clk_en && osc_en && !core_reset && !ram_access_inhibit;

    a_r1_idle_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && idle_req && !pd_req && !rst_pin) |=> (!cpu_clk_en && periph_clk_en && osc_en));

    a_r2_pd_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && pd_req && !rst_pin) |=> (!cpu_clk_en && !periph_clk_en && !osc_en));

    a_r3_irq_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_clk_en && periph_clk_en && !rst_pin && ((irq_pend & irq_en) != '0)) |=> cpu_clk_en);

    a_r4_pd_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en && !rst_pin) |=> !osc_en);

    a_r4_pd_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> (!cpu_clk_en && !periph_clk_en));

    a_r5_reset_needs_pin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_reset) |-> $past(rst_pin));

    a_r6_hold_while_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (core_reset && rst_pin) |=> core_reset);

    a_r7_inhibit_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_access_inhibit) |-> ($past(rst_pin) && cpu_clk_en));

    a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        core_reset |-> !ram_access_inhibit);

    a_r9_pin_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && rst_pin) |=> (cpu_clk_en && osc_en));

endmodule

bind pwr_state_ctrl pwr_state_ctrl_chk #(.NUM_IRQ(NUM_IRQ)) chk_i (
    .clk                (clk),
    .rst_n              (rst_n),
    .rst_pin            (rst_pin),
    .idle_req           (idle_req),
    .pd_req             (pd_req),
    .irq_pend           (irq_pend),
    .irq_en             (irq_en),
    .cpu_clk_en         (cpu_clk_en),
    .periph_clk_en      (periph_clk_en),
    .osc_en             (osc_en),
    .ram_access_inhibit (ram_access_inhibit),
    .core_reset         (core_reset)
);

// File: tb/pwr_state_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_state_ctrl_tb_top;
    localparam int MC    = 3;
    localparam int MINMC = 2;
    localparam int LIM   = MC * MINMC;
    localparam int HOLD  = 5;
    localparam int NI    = 3;

    // {cpu, per, osc, inhibit, core_reset}
    localparam logic [4:0] O_RUN  = 5'b11100;
    localparam logic [4:0] O_IDLE = 5'b01100;
    localparam logic [4:0] O_PD   = 5'b00000;
    localparam logic [4:0] O_HOLD = 5'b11101;
    localparam logic [4:0] O_INH  = 5'b11110;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rst_pin = 1'b0, idle_req = 1'b0, pd_req = 1'b0;
    logic [NI-1:0] irq_pend = '0, irq_en = '0;
    logic cpu, per, osc, inh, crst;
    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    pwr_state_ctrl #(.MC_CLKS(MC), .MIN_RST_MC(MINMC), .HOLD_CYCLES(HOLD), .NUM_IRQ(NI)) dut_i (
        .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .idle_req(idle_req), .pd_req(pd_req),
        .irq_pend(irq_pend), .irq_en(irq_en), .cpu_clk_en(cpu), .periph_clk_en(per),
        .osc_en(osc), .ram_access_inhibit(inh), .core_reset(crst)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic expect_o(input string tag, input logic [4:0] exp);
        logic [4:0] act;
        act = {cpu, per, osc, inh, crst};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    // Full valid reset pulse, then the settling count (R5, R6)
    task automatic hw_reset(input string tag);
        rst_pin = 1'b1;
        for (int k = 1; k <= LIM; k++) begin
            step();
            if (k == LIM) expect_o({tag, " R5 valid at limit"}, O_HOLD);
        end
        rst_pin = 1'b0;
        for (int k = 1; k <= HOLD; k++) begin
            step();
            expect_o({tag, " R6 settle"}, (k < HOLD) ? O_HOLD : O_RUN);
        end
    endtask

    task automatic enter_idle();
        idle_req = 1'b1;
        step();
        idle_req = 1'b0;
        expect_o("R1 idle entry", O_IDLE);
    endtask

    initial begin
        // R8 power-on
        step();
        step();
        expect_o("R8 during rst_n", O_HOLD);
        rst_n = 1'b1;
        for (int k = 1; k <= HOLD; k++) begin
            step();
            expect_o("R8 power-on settle", (k < HOLD) ? O_HOLD : O_RUN);
        end

        // R1/R2 request combinations from run
        for (int c = 0; c < 4; c++) begin
            idle_req = c[0];
            pd_req   = c[1];
            step();
            idle_req = 1'b0;
            pd_req   = 1'b0;
            if (c[1]) begin
                expect_o("R2 pd entry", O_PD);
                hw_reset("R2 exit");
            end else if (c[0]) begin
                expect_o("R1 idle entry", O_IDLE);
                irq_pend = '1; irq_en = '1;
                step();
                irq_pend = '0; irq_en = '0;
                expect_o("R3 wake", O_RUN);
            end else begin
                expect_o("R2 no request", O_RUN);
            end
        end

        // R3 every pending/enable pattern
        for (int p = 0; p < (1 << NI); p++) begin
            for (int e = 0; e < (1 << NI); e++) begin
                enter_idle();
                irq_pend = NI'(p);
                irq_en   = NI'(e);
                step();
                expect_o("R3 wake decision", ((p & e) != 0) ? O_RUN : O_IDLE);
                if ((p & e) == 0) begin
                    irq_pend = '1; irq_en = '1;
                    step();
                    expect_o("R3 wake after mask", O_RUN);
                end
                irq_pend = '0; irq_en = '0;
            end
        end

        // R4 power-down ignores everything but a valid reset
        pd_req = 1'b1;
        step();
        pd_req = 1'b0;
        expect_o("R2 pd entry", O_PD);
        irq_pend = '1; irq_en = '1; idle_req = 1'b1;
        for (int len = 1; len < LIM; len++) begin
            rst_pin = 1'b1;
            for (int k = 0; k < len; k++) begin
                step();
                expect_o("R4 pd short pulse", O_PD);
            end
            rst_pin = 1'b0;
            step();
            expect_o("R4 pd after pulse", O_PD);
        end
        irq_pend = '0; irq_en = '0; idle_req = 1'b0;
        hw_reset("R4 exit");

        // R5/R9 short pulses in run, requests held high
        for (int len = 1; len < LIM; len++) begin
            rst_pin = 1'b1; idle_req = 1'b1; pd_req = 1'b1;
            for (int k = 0; k < len; k++) begin
                step();
                expect_o("R5 R9 short pulse in run", O_RUN);
            end
            rst_pin = 1'b0; idle_req = 1'b0; pd_req = 1'b0;
            step();
            expect_o("R5 after short pulse", O_RUN);
        end

        // R6 long pulse: reset holds while the pin stays high
        rst_pin = 1'b1;
        for (int k = 1; k <= LIM + 4; k++) begin
            step();
            expect_o("R5 R6 long pulse", (k >= LIM) ? O_HOLD : O_RUN);
        end
        rst_pin = 1'b0;
        for (int k = 1; k <= HOLD; k++) begin
            step();
            expect_o("R6 settle after long", (k < HOLD) ? O_HOLD : O_RUN);
        end

        // R7 reset pin while idle
        for (int len = 1; len < LIM; len++) begin
            enter_idle();
            rst_pin = 1'b1;
            for (int k = 0; k < len; k++) begin
                step();
                expect_o("R7 inhibit window", O_INH);
            end
            rst_pin = 1'b0;
            idle_req = 1'b1;
            step();
            idle_req = 1'b0;
            expect_o("R7 R9 inhibit clears, request ignored", O_RUN);
        end
        enter_idle();
        rst_pin = 1'b1;
        for (int k = 1; k <= LIM; k++) begin
            step();
            expect_o("R7 inhibit until reset", (k == LIM) ? O_HOLD : O_INH);
        end
        rst_pin = 1'b0;
        for (int k = 1; k <= HOLD; k++) begin
            step();
            expect_o("R7 settle", (k < HOLD) ? O_HOLD : O_RUN);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 20);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule